// File: doc/BRIEF.md
# Two-Dimensional DMA Burst Address Generator

This block turns one DMA request into the sequence of bus bursts that carry it. A request is a rectangle in memory: a number of rows, each a fixed number of bytes long. Consecutive rows begin a fixed stride apart. The controller that owns the registers presents the request on the inputs and pulses `start_i`. The block captures the fields in that cycle. It then offers burst descriptors (address and byte count) one at a time under a valid/ready handshake. After the last burst of the last row is accepted, it raises a one-cycle completion pulse.

Row length and row count arrive in minus-one form, so zero means one byte or one row. Each row is cut into bursts. A burst is never longer than a configurable number of bus beats, and it never crosses a 4 KiB page. The first row begins at the start address. Every later row begins at the previous row's start plus the stride, so gaps between rows are allowed. If two-dimensional support is removed by parameter, the row count is ignored and the request is always a single row. Requests whose address, length or used stride are not whole multiples of the bus width are refused with an error pulse. The address of the pending burst is always visible on a status output.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and just after it, no burst is offered and the done, busy and error outputs are low; the current address reads zero.
- R2: An accepted request yields bursts whose byte counts add up to (row length field + 1) × (row count field + 1). The first burst starts at the start address. The end of the last burst equals start + row count field × stride + row length field + 1.
- R3: Every burst carries between 1 and MAX_BEATS × BEAT_BYTES bytes inclusive (128 with the defaults).
- R4: No burst crosses a PAGE_BYTES (4096) address boundary: the address modulo 4096 plus the byte count never exceeds 4096.
- R5: The first burst of each row after the first has the address of the previous row's first burst plus the captured stride.
- R6: A row count field of zero gives exactly one row, and the stride is then neither checked nor used, so a misaligned stride is accepted.
- R7: With HAS_2D = 0 the row count field is ignored: total bytes equal the row length field + 1.
- R8: A request is refused when the start address is not a multiple of BEAT_BYTES (8), when the row length field's low three bits are not all ones, or when a multi-row request has a stride that is not a multiple of 8. The block then pulses `cfg_err_o` for one cycle in the cycle after the start, never becomes busy and offers no burst.
- R9: A start pulse while busy is ignored, and input changes during a run have no effect on it.
- R10: `done_o` is high for exactly one cycle: the cycle after the handshake of the final burst.
- R11: While a burst is offered and not accepted, its address and byte count hold steady and the offer stays up.
- R12: While a burst is offered, `cur_addr_o` shows that burst's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse; fields are captured with it |
| base_addr_i | input | ADDR_W | Start address of the first row |
| xlen_m1_i | input | XLEN_W | Row length in bytes minus one |
| ylen_m1_i | input | YLEN_W | Row count minus one |
| stride_i | input | ADDR_W | Distance between row starts in bytes |
| burst_valid_o | output | 1 | A burst descriptor is offered |
| burst_ready_i | input | 1 | Consumer accepts the offered burst |
| burst_addr_o | output | ADDR_W | Burst start address |
| burst_bytes_o | output | clog2(MAX_BEATS*BEAT_BYTES+1) | Burst byte count |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A request is in progress |
| cfg_err_o | output | 1 | One-cycle pulse on a refused request |
| cur_addr_o | output | ADDR_W | Current burst address for status reads |

## Verification
The properties make no assumption about `burst_ready_i`. It may drop or stay low for any length of time, and the stimulus does both: it accepts every cycle for some requests and only one cycle in three for others. They also allow `start_i` to arrive at any cycle, including while busy. The stimulus deliberately pulses it mid-run with different fields. The page and burst-size properties assume that the start address and stride are whole beats, as every accepted request guarantees. Misaligned values reach the block only in requests that it must refuse, or as an unused stride on a single-row request.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_BURST = 2'd1,
        GEN_DONE  = 2'd2
    } gen_state_e;

endpackage

// File: rtl/dma2d_burst_size.sv
module dma2d_burst_size #(
    parameter int PAGE_LOG2 = 12,
    parameter int REM_W     = 25,
    parameter int MAX_BYTES = 128,
    parameter int BYTES_W   = 8
) (
    input  logic [PAGE_LOG2-1:0] addr_lo_i,
    input  logic [REM_W-1:0]     remain_i,
    output logic [BYTES_W-1:0]   bytes_o
);

    localparam int CMP_W = (REM_W > PAGE_LOG2 + 1) ? REM_W : PAGE_LOG2 + 1;

    logic [CMP_W-1:0] to_page;
    logic [CMP_W-1:0] remain_w;
    logic [CMP_W-1:0] cap;
    logic [CMP_W-1:0] pick;

    // Smallest of: bytes left in the row, the burst cap, bytes to the page end.
    always_comb begin
        to_page  = CMP_W'(1 << PAGE_LOG2) - CMP_W'(addr_lo_i);
        remain_w = CMP_W'(remain_i);
        cap      = CMP_W'(MAX_BYTES);
        pick     = remain_w;
        if (cap < pick) begin
            pick = cap;
        end
        if (to_page < pick) begin
            pick = to_page;
        end
        bytes_o = pick[BYTES_W-1:0];
    end

endmodule

// File: rtl/dma2d_align_check.sv
module dma2d_align_check #(
    parameter int ALIGN_LOG2 = 3,
    parameter bit HAS_2D     = 1'b1
) (
    input  logic [ALIGN_LOG2-1:0] base_lo_i,
    input  logic [ALIGN_LOG2-1:0] xlen_lo_i,
    input  logic [ALIGN_LOG2-1:0] stride_lo_i,
    input  logic                  multi_row_i,
    output logic                  ok_o
);

    logic stride_ok;

    generate
        if (HAS_2D) begin : g_stride_chk
            // The stride only matters when a second row exists.
            assign stride_ok = !multi_row_i || (stride_lo_i == '0);
        end else begin : g_no_stride
            assign stride_ok = 1'b1;
        end
    endgenerate

    // Length is programmed minus one, so a whole number of beats ends in all ones.
    assign ok_o = (base_lo_i == '0) && (&xlen_lo_i) && stride_ok;

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int XLEN_W     = 24,
    parameter int YLEN_W     = 16,
    parameter int BEAT_BYTES = 8,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096,
    parameter bit HAS_2D     = 1'b1
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start_i,
    input  logic [ADDR_W-1:0]                            base_addr_i,
    input  logic [XLEN_W-1:0]                            xlen_m1_i,
    input  logic [YLEN_W-1:0]                            ylen_m1_i,
    input  logic [ADDR_W-1:0]                            stride_i,
    output logic                                         burst_valid_o,
    input  logic                                         burst_ready_i,
    output logic [ADDR_W-1:0]                            burst_addr_o,
    output logic [$clog2(MAX_BEATS*BEAT_BYTES+1)-1:0]    burst_bytes_o,
    output logic                                         done_o,
    output logic                                         busy_o,
    output logic                                         cfg_err_o,
    output logic [ADDR_W-1:0]                            cur_addr_o
);

    localparam int MAX_BYTES  = MAX_BEATS * BEAT_BYTES;
    localparam int BYTES_W    = $clog2(MAX_BYTES + 1);
    localparam int ALIGN_LOG2 = $clog2(BEAT_BYTES);
    localparam int PAGE_LOG2  = $clog2(PAGE_BYTES);
    localparam int REM_W      = XLEN_W + 1;

    typedef struct packed {
        gen_state_e          state;
        logic [ADDR_W-1:0]   cur_addr;
        logic [ADDR_W-1:0]   row_start;
        logic [ADDR_W-1:0]   stride;
        logic [REM_W-1:0]    row_len;
        logic [REM_W-1:0]    row_left;
        logic [YLEN_W-1:0]   rows_left;
        logic                err;
    } gen_regs_t;

    localparam gen_regs_t REGS_RESET = '{
        state:     GEN_IDLE,
        cur_addr:  '0,
        row_start: '0,
        stride:    '0,
        row_len:   '0,
        row_left:  '0,
        rows_left: '0,
        err:       1'b0
    };

    gen_regs_t regs_d, regs_q;

    logic [YLEN_W-1:0]  rows_init;
    logic               cfg_ok;
    logic [BYTES_W-1:0] bsize;
    logic [REM_W-1:0]   first_len;
    logic [ADDR_W-1:0]  next_row;

    generate
        if (HAS_2D) begin : g_rows_2d
            assign rows_init = ylen_m1_i;
        end else begin : g_rows_1d
            assign rows_init = '0;
        end
    endgenerate

    dma2d_align_check #(
        .ALIGN_LOG2 (ALIGN_LOG2),
        .HAS_2D     (HAS_2D)
    ) u_align (
        .base_lo_i   (base_addr_i[ALIGN_LOG2-1:0]),
        .xlen_lo_i   (xlen_m1_i[ALIGN_LOG2-1:0]),
        .stride_lo_i (stride_i[ALIGN_LOG2-1:0]),
        .multi_row_i (rows_init != '0),
        .ok_o        (cfg_ok)
    );

    dma2d_burst_size #(
        .PAGE_LOG2 (PAGE_LOG2),
        .REM_W     (REM_W),
        .MAX_BYTES (MAX_BYTES),
        .BYTES_W   (BYTES_W)
    ) u_bsize (
        .addr_lo_i (regs_q.cur_addr[PAGE_LOG2-1:0]),
        .remain_i  (regs_q.row_left),
        .bytes_o   (bsize)
    );

    assign first_len = REM_W'(xlen_m1_i) + REM_W'(1);
    assign next_row  = regs_q.row_start + regs_q.stride;

    always_comb begin
        regs_d     = regs_q;
        regs_d.err = 1'b0;
        unique case (regs_q.state)
            GEN_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        regs_d.state     = GEN_BURST;
                        regs_d.cur_addr  = base_addr_i;
                        regs_d.row_start = base_addr_i;
                        regs_d.stride    = (rows_init != '0) ? stride_i : '0;
                        regs_d.row_len   = first_len;
                        regs_d.row_left  = first_len;
                        regs_d.rows_left = rows_init;
                    end else begin
                        regs_d.err = 1'b1;
                    end
                end
            end
            GEN_BURST: begin
                if (burst_ready_i) begin
                    if (regs_q.row_left == REM_W'(bsize)) begin
                        if (regs_q.rows_left == '0) begin
                            regs_d.state = GEN_DONE;
                        end else begin
                            regs_d.row_start = next_row;
                            regs_d.cur_addr  = next_row;
                            regs_d.row_left  = regs_q.row_len;
                            regs_d.rows_left = regs_q.rows_left - YLEN_W'(1);
                        end
                    end else begin
                        regs_d.cur_addr = regs_q.cur_addr + ADDR_W'(bsize);
                        regs_d.row_left = regs_q.row_left - REM_W'(bsize);
                    end
                end
            end
            GEN_DONE: begin
                regs_d.state = GEN_IDLE;
            end
            default: begin
                regs_d.state = GEN_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign burst_valid_o = (regs_q.state == GEN_BURST);
    assign burst_addr_o  = regs_q.cur_addr;
    assign burst_bytes_o = bsize;
    assign done_o        = (regs_q.state == GEN_DONE);
    assign busy_o        = (regs_q.state != GEN_IDLE);
    assign cfg_err_o     = regs_q.err;
    assign cur_addr_o    = regs_q.cur_addr;

endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
    parameter int ADDR_W    = 32,
    parameter int BYTES_W   = 8,
    parameter int MAX_BYTES = 128,
    parameter int PAGE_LOG2 = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               burst_valid_o,
    input logic               burst_ready_i,
    input logic [ADDR_W-1:0]  burst_addr_o,
    input logic [BYTES_W-1:0] burst_bytes_o,
    input logic               done_o,
    input logic               busy_o,
    input logic               cfg_err_o
);

    logic [31:0] span;
    assign span = 32'(burst_addr_o[PAGE_LOG2-1:0]) + 32'(burst_bytes_o);

    a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid_o && !burst_ready_i) |=>
            (burst_valid_o && $stable(burst_addr_o) && $stable(burst_bytes_o)));

    a_r3_burst_size: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid_o |-> ((burst_bytes_o != '0) && (32'(burst_bytes_o) <= 32'(MAX_BYTES))));

    a_r4_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid_o |-> (span <= 32'(1 << PAGE_LOG2)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(burst_valid_o && burst_ready_i));

    a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!busy_o && !burst_valid_o));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

bind dma2d_addr_gen dma2d_checker #(
    .ADDR_W    (ADDR_W),
    .BYTES_W   (BYTES_W),
    .MAX_BYTES (MAX_BYTES),
    .PAGE_LOG2 (PAGE_LOG2)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .burst_valid_o (burst_valid_o),
    .burst_ready_i (burst_ready_i),
    .burst_addr_o  (burst_addr_o),
    .burst_bytes_o (burst_bytes_o),
    .done_o        (done_o),
    .busy_o        (busy_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_b = 1'b0;
    logic [31:0] base_addr = '0;
    logic [23:0] xlen_m1 = '0;
    logic [15:0] ylen_m1 = '0;
    logic [31:0] stride = '0;
    logic        ready = 1'b0;

    logic        valid, done, busy, err;
    logic [31:0] baddr, cur_addr;
    logic [7:0]  bbytes;
    logic        valid_b, done_b, busy_b, err_b;
    logic [31:0] baddr_b, cur_addr_b;
    logic [7:0]  bbytes_b;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma2d_addr_gen i_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .base_addr_i(base_addr), .xlen_m1_i(xlen_m1), .ylen_m1_i(ylen_m1),
        .stride_i(stride), .burst_valid_o(valid), .burst_ready_i(ready),
        .burst_addr_o(baddr), .burst_bytes_o(bbytes), .done_o(done),
        .busy_o(busy), .cfg_err_o(err), .cur_addr_o(cur_addr)
    );

    dma2d_addr_gen #(.HAS_2D(1'b0)) i_dma2d_addr_gen_1d (
        .clk(clk), .rst_n(rst_n), .start_i(start_b),
        .base_addr_i(base_addr), .xlen_m1_i(xlen_m1), .ylen_m1_i(ylen_m1),
        .stride_i(stride), .burst_valid_o(valid_b), .burst_ready_i(1'b1),
        .burst_addr_o(baddr_b), .burst_bytes_o(bbytes_b), .done_o(done_b),
        .busy_o(busy_b), .cfg_err_o(err_b), .cur_addr_o(cur_addr_b)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [23:0] x;
        logic [15:0] y;
        logic [31:0] stride;
        logic [7:0]  nbursts;
        logic        slow_ready;
        logic        poke;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 24'd63,  16'd0, 32'h0,      8'd1, 1'b0, 1'b0},
        '{32'h0000_2000, 24'd255, 16'd2, 32'h400,    8'd6, 1'b1, 1'b1},
        '{32'h0000_0FC0, 24'd127, 16'd0, 32'h0,      8'd2, 1'b1, 1'b0},
        '{32'h0000_3008, 24'd7,   16'd3, 32'h10,     8'd4, 1'b0, 1'b0},
        '{32'h0000_0F80, 24'd199, 16'd1, 32'h1000,   8'd4, 1'b1, 1'b0},
        '{32'h0000_5010, 24'd135, 16'd0, 32'h0,      8'd2, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_job(input vec_t v);
        longint total = 0;
        longint row_acc = 0;
        longint row_len = longint'(v.x) + 1;
        longint row_idx = 0;
        longint prev_row = 0;
        longint last_end = 0;
        int     count = 0;
        int     last_hs = -10;
        int     done_at = -1;
        bit     stall = 1'b0;
        logic [31:0] stall_addr = '0;
        logic [7:0]  stall_bytes = '0;
        base_addr = v.base; xlen_m1 = v.x; ylen_m1 = v.y; stride = v.stride;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !err, "R2", "accepted request busy", {busy, err}, 2'b10);
        for (int i = 0; i < 4000; i++) begin
            if (done) begin
                done_at = i;
                break;
            end
            if (stall) begin
                chk(valid && baddr == stall_addr && bbytes == stall_bytes, "R11",
                    "stalled burst held", baddr, stall_addr);
            end
            if (v.poke && i == 2) begin
                start = 1'b1; base_addr = 32'h9000_0000; xlen_m1 = 24'd7;
                ylen_m1 = 16'd0; stride = 32'h8;
            end else begin
                start = 1'b0;
            end
            ready = v.slow_ready ? (i % 3 == 2) : 1'b1;
            if (valid) begin
                chk(cur_addr == baddr, "R12", "status address", cur_addr, baddr);
            end
            if (valid && ready) begin
                chk(bbytes != 0 && bbytes <= 8'd128, "R3", "burst size", bbytes, 128);
                chk(longint'(baddr[11:0]) + longint'(bbytes) <= 4096, "R4",
                    "page crossing", longint'(baddr[11:0]) + longint'(bbytes), 4096);
                if (row_acc == 0) begin
                    if (row_idx == 0) begin
                        chk(baddr == v.base, "R2", "first burst address", baddr, v.base);
                    end else begin
                        chk(longint'(baddr) == prev_row + longint'(v.stride), "R5",
                            "row start", baddr, prev_row + longint'(v.stride));
                    end
                    prev_row = longint'(baddr);
                end
                count++;
                total += longint'(bbytes);
                row_acc += longint'(bbytes);
                last_end = longint'(baddr) + longint'(bbytes);
                if (row_acc >= row_len) begin
                    row_acc = 0;
                    row_idx++;
                end
                last_hs = i;
                stall = 1'b0;
            end else if (valid) begin
                stall = 1'b1; stall_addr = baddr; stall_bytes = bbytes;
            end
            @(negedge clk);
        end
        start = 1'b0;
        ready = 1'b0;
        chk(count == int'(v.nbursts), "R2", "burst count", count, v.nbursts);
        chk(total == row_len * (longint'(v.y) + 1), "R2", "total bytes",
            total, row_len * (longint'(v.y) + 1));
        chk(last_end == longint'(v.base) + longint'(v.y) * longint'(v.stride) + row_len,
            "R5", "end of last burst", last_end,
            longint'(v.base) + longint'(v.y) * longint'(v.stride) + row_len);
        chk(done_at == last_hs + 1, "R10", "done timing", done_at, last_hs + 1);
        @(negedge clk);
        chk(!done && !busy && !valid, "R9", "idle after done, mid-run start ignored",
            {done, busy, valid}, 0);
    endtask

    task automatic run_bad(input logic [31:0] b, input logic [23:0] x,
                           input logic [15:0] y, input logic [31:0] s);
        base_addr = b; xlen_m1 = x; ylen_m1 = y; stride = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err && !busy && !valid, "R8", "refused request", {err, busy, valid}, 3'b100);
        @(negedge clk);
        chk(!err && !busy && !valid, "R8", "error pulse one cycle", {err, busy, valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!valid && !done && !busy && !err && cur_addr == 0, "R1", "state in reset",
            {valid, done, busy, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid && !done && !busy && !err, "R1", "state after reset",
            {valid, done, busy, err}, 0);

        for (int k = 0; k < NVEC; k++) begin
            run_job(VECS[k]);
        end

        // R6: single row, misaligned stride is irrelevant
        run_job('{32'h0000_6000, 24'd31, 16'd0, 32'h3, 8'd1, 1'b0, 1'b0});

        // R8: refused requests
        run_bad(32'h0000_1004, 24'd63, 16'd0, 32'h0);
        run_bad(32'h0000_1000, 24'd10, 16'd0, 32'h0);
        run_bad(32'h0000_1000, 24'd63, 16'd1, 32'h104);

        // R7: one-dimensional build ignores the row count
        begin
            longint tot = 0;
            int     nb = 0;
            bit     seen = 1'b0;
            base_addr = 32'h0000_7000; xlen_m1 = 24'd63; ylen_m1 = 16'd3;
            stride = 32'h100;
            start_b = 1'b1;
            @(negedge clk);
            start_b = 1'b0;
            for (int i = 0; i < 200; i++) begin
                if (done_b) begin
                    seen = 1'b1;
                    break;
                end
                if (valid_b) begin
                    nb++;
                    tot += longint'(bbytes_b);
                end
                @(negedge clk);
            end
            chk(seen, "R7", "1D done seen", seen, 1);
            chk(tot == 64, "R7", "1D total bytes", tot, 64);
            chk(nb == 1, "R7", "1D burst count", nb, 1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule